// File: doc/BRIEF.md
# Multiplexed four-digit display counter

This block counts pulses on a slow count clock in four binary-coded decimal digits and drives a scanned seven-segment display from them. A holding register placed after the counter can be kept open so that it tracks the count, or closed to freeze a reading while counting goes on. A display selector chooses between the live count and the frozen reading. The display is scanned one digit at a time from a separate system clock, which is divided down by a prescaler to set how long each digit is shown.

A build parameter chooses one of three counting styles. Plain decade counts 0000 to 9999. Clock style limits the second-highest digit to 0..5, so that a 10 Hz input reads minutes, seconds and tenths up to 9:59.9. Half-digit style limits the top digit to 0..1 and turns the carry output into an overflow flag. The carry output in the first two styles is high from 6000 until the count returns to 0000, so it can drive the count clock of a following stage.

Top module: `disp_counter4`

## Requirements
- R1: A high `rst` asynchronously clears all four digits, the holding register and `carry_out`. After release the display reads 0000 and `carry_out` is low.
- R2: The count advances by one only on a falling edge of `cnt_clk`. A rising edge leaves the count unchanged.
- R3: In plain decade mode (MODE = CNT_DECADE) every digit counts 0..9. A digit at 9 returns to 0 and carries one into the next higher digit, and 9999 wraps to 0000.
- R4: In clock mode (MODE = CNT_CLOCK) digit index 2 (the second from the top) counts 0..5, so 0599 is followed by 1000 and 9599 wraps to 0000. The other digits count 0..9.
- R5: In half-digit mode (MODE = CNT_HALF) the top digit (index 3) counts 0..1. The count after 1999 is 0000, and at that step `carry_out` goes high. It then stays high through any further counting until `rst`.
- R6: In plain and clock modes `carry_out` goes high on the step at which the count becomes 6000. It stays high until the step at which the count becomes 0000, where it goes low.
- R7: While `latch_open` is high the holding register follows the count. While it is low the register keeps its value. With `show_live` high the display shows the live count. With `show_live` low it shows the holding register, and this reading does not change while counting continues.
- R8: Exactly one bit of `dig_en` is high at any time, with bit k enabling digit k (k = 0 is the least significant). The active bit steps 0,1,2,3,0,... and each digit stays active for PRESC_DIV cycles of `scan_clk`.
- R9: `seg` carries the active digit in active-high gfedcba order (bit 0 = a, bit 6 = g): 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cnt_clk | input | 1 | Count clock. Each falling edge adds one to the count |
| scan_clk | input | 1 | Free-running system clock for the display scan |
| rst | input | 1 | Active-high reset, asynchronous to the counter |
| latch_open | input | 1 | High: holding register follows the count. Low: it holds |
| show_live | input | 1 | High: display the live count. Low: display the holding register |
| seg | output | 7 | Segment lines, gfedcba, active high |
| dig_en | output | 4 | One-hot digit enable, bit 0 = least significant digit |
| carry_out | output | 1 | Cascade carry or overflow flag, depending on MODE |

## Verification
Three copies of the block run side by side, one in each mode, so that each digit-limit corner is seen: 0009→0010 and 9999→0000 in plain decade, 0599→1000 and 9599→0000 in clock mode, and 1999→0000 in half-digit mode. A wrong modulus would show a digit reading 6 in the clock digit or 2 in the top digit. `carry_out` is compared after every count step. A missed edge would show as a flag that rises one count late, drops at the wrong point, or is not sticky after overflow. Random sequences of open and closed holding with both display choices catch a register that leaks the live count while it should be frozen. The bench also checks that a rising count edge does not advance the count, and it watches the scan order, the dwell time and each segment pattern.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
    localparam int NDIG = 4;
    localparam int DW   = 4;

    typedef enum logic [1:0] {
        CNT_DECADE = 2'd0,
        CNT_CLOCK  = 2'd1,
        CNT_HALF   = 2'd2
    } cnt_mode_e;

    typedef logic [DW-1:0]            bcd_t;
    typedef logic [NDIG-1:0][DW-1:0]  bcd_word_t;

    typedef struct packed {
        bcd_word_t digits;
        logic      carry;
    } cnt_state_t;

    // highest value a digit position reaches in a given mode
    function automatic bcd_t digit_max(cnt_mode_e m, int idx);
        if (m == CNT_CLOCK && idx == NDIG - 2) return 4'd5;
        if (m == CNT_HALF && idx == NDIG - 1)  return 4'd1;
        return 4'd9;
    endfunction

    // count value at which the cascade carry turns on
    function automatic bcd_word_t carry_mark();
        bcd_word_t w;
        w = '0;
        w[NDIG-1] = 4'd6;
        return w;
    endfunction

    // active-high gfedcba, bit 0 = segment a
    function automatic logic [6:0] seg_encode(bcd_t d);
        case (d)
            4'd0:    return 7'h3F;
            4'd1:    return 7'h06;
            4'd2:    return 7'h5B;
            4'd3:    return 7'h4F;
            4'd4:    return 7'h66;
            4'd5:    return 7'h6D;
            4'd6:    return 7'h7D;
            4'd7:    return 7'h07;
            4'd8:    return 7'h7F;
            4'd9:    return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction
endpackage

// File: rtl/dcnt_counter.sv
module dcnt_counter
    import dcnt_pkg::*;
#(
    parameter cnt_mode_e MODE = CNT_DECADE
) (
    input  logic       cnt_clk,
    input  logic       rst,
    output cnt_state_t state_o
);
    localparam bcd_word_t MARK = carry_mark();

    bcd_word_t       dig_q, dig_d;
    logic            carry_q, carry_d;
    logic            seen_q;
    logic [NDIG-1:0] at_max;
    logic [NDIG:0]   inc;

    generate
        for (genvar i = 0; i < NDIG; i++) begin : g_digit
            localparam bcd_t MAXV = digit_max(MODE, i);
            assign at_max[i] = (dig_q[i] == MAXV);
            assign dig_d[i]  = !inc[i] ? dig_q[i] :
                               (at_max[i] ? 4'd0 : dig_q[i] + 4'd1);

            assert_digit_range_R3: assert property (@(negedge cnt_clk) disable iff (rst)
                dig_q[i] <= MAXV);
        end
    endgenerate

    always_comb begin
        inc[0] = 1'b1;
        for (int j = 1; j <= NDIG; j++) inc[j] = inc[j-1] & at_max[j-1];
    end

    always_comb begin
        carry_d = carry_q;
        if (MODE == CNT_HALF) begin
            if (inc[NDIG]) carry_d = 1'b1;
        end else begin
            if (dig_d == '0)        carry_d = 1'b0;
            else if (dig_d == MARK) carry_d = 1'b1;
        end
    end

    always_ff @(negedge cnt_clk or posedge rst) begin
        if (rst) begin
            dig_q   <= '0;
            carry_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            dig_q   <= dig_d;
            carry_q <= carry_d;
            seen_q  <= 1'b1;
        end
    end

    assign state_o.digits = dig_q;
    assign state_o.carry  = carry_q;

    assert_overflow_sticky_R5: assert property (@(negedge cnt_clk) disable iff (rst)
        (MODE == CNT_HALF && seen_q && $past(carry_q)) |-> carry_q);

    assert_carry_rise_at_mark_R6: assert property (@(negedge cnt_clk) disable iff (rst)
        (MODE != CNT_HALF && seen_q && $rose(carry_q)) |-> (dig_q == MARK));
endmodule

// File: rtl/dcnt_hold.sv
module dcnt_hold
    import dcnt_pkg::*;
(
    input  logic      rst,
    input  logic      open_i,
    input  bcd_word_t live_i,
    output bcd_word_t held_o
);
    bcd_word_t held_q;

    always_latch begin
        if (rst)         held_q <= '0;
        else if (open_i) held_q <= live_i;
    end

    assign held_o = held_q;
endmodule

// File: rtl/dcnt_scan.sv
module dcnt_scan
    import dcnt_pkg::*;
#(
    parameter int PRESC_DIV = 1024
) (
    input  logic            scan_clk,
    input  logic            rst,
    input  bcd_word_t       value_i,
    output logic [6:0]      seg_o,
    output logic [NDIG-1:0] dig_en_o
);
    localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam int IW = $clog2(NDIG);

    bcd_word_t       sync1_q, sync2_q;
    logic [PW-1:0]   presc_q;
    logic [IW-1:0]   idx_q;
    logic            tick;

    assign tick = (presc_q == PW'(PRESC_DIV - 1));

    always_ff @(posedge scan_clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            presc_q <= '0;
            idx_q   <= '0;
        end else begin
            sync1_q <= value_i;
            sync2_q <= sync1_q;
            presc_q <= tick ? '0 : presc_q + PW'(1);
            if (tick) idx_q <= (idx_q == IW'(NDIG - 1)) ? '0 : idx_q + IW'(1);
        end
    end

    always_comb begin
        dig_en_o        = '0;
        dig_en_o[idx_q] = 1'b1;
    end

    assign seg_o = seg_encode(sync2_q[idx_q]);

    assert_single_digit_R8: assert property (@(posedge scan_clk) disable iff (rst)
        $countones(dig_en_o) == 1);

    assert_dwell_hold_R8: assert property (@(posedge scan_clk) disable iff (rst)
        !tick |=> $stable(dig_en_o));

    assert_dwell_step_R8: assert property (@(posedge scan_clk) disable iff (rst)
        tick |=> !$stable(dig_en_o));
endmodule

// File: rtl/disp_counter4.sv
module disp_counter4
    import dcnt_pkg::*;
#(
    parameter cnt_mode_e MODE      = CNT_DECADE,
    parameter int        PRESC_DIV = 1024
) (
    input  logic       cnt_clk,
    input  logic       scan_clk,
    input  logic       rst,
    input  logic       latch_open,
    input  logic       show_live,
    output logic [6:0] seg,
    output logic [3:0] dig_en,
    output logic       carry_out
);
    cnt_state_t cnt_st;
    bcd_word_t  held, shown;

    dcnt_counter #(.MODE(MODE)) u_counter (
        .cnt_clk (cnt_clk),
        .rst     (rst),
        .state_o (cnt_st)
    );

    dcnt_hold u_hold (
        .rst    (rst),
        .open_i (latch_open),
        .live_i (cnt_st.digits),
        .held_o (held)
    );

    assign shown     = show_live ? cnt_st.digits : held;
    assign carry_out = cnt_st.carry;

    dcnt_scan #(.PRESC_DIV(PRESC_DIV)) u_scan (
        .scan_clk (scan_clk),
        .rst      (rst),
        .value_i  (shown),
        .seg_o    (seg),
        .dig_en_o (dig_en)
    );

    assert_hold_frozen_R7: assert property (@(posedge scan_clk) disable iff (rst)
        (!latch_open && !$past(latch_open)) |-> $stable(held));
endmodule

// File: tb/disp_counter4_tb_top.sv
module disp_counter4_tb_top;
    import dcnt_pkg::*;

    localparam int PD = 4;

    logic       clk = 1'b0;
    logic       cnt_clk = 1'b0;
    logic       rst = 1'b0;
    logic       latch_open = 1'b1;
    logic       show_live = 1'b1;
    logic [6:0] seg_w   [3];
    logic [3:0] dig_w   [3];
    logic       carry_w [3];

    int checks = 0;
    int errors = 0;
    int mdig [3][4];
    int mcar [3];
    int mhold;

    always #5 clk = ~clk;

    disp_counter4 #(.MODE(CNT_DECADE), .PRESC_DIV(PD)) dut_i (
        .cnt_clk(cnt_clk), .scan_clk(clk), .rst(rst), .latch_open(latch_open),
        .show_live(show_live), .seg(seg_w[0]), .dig_en(dig_w[0]), .carry_out(carry_w[0]));

    disp_counter4 #(.MODE(CNT_CLOCK), .PRESC_DIV(PD)) dut_clock_i (
        .cnt_clk(cnt_clk), .scan_clk(clk), .rst(rst), .latch_open(latch_open),
        .show_live(show_live), .seg(seg_w[1]), .dig_en(dig_w[1]), .carry_out(carry_w[1]));

    disp_counter4 #(.MODE(CNT_HALF), .PRESC_DIV(PD)) dut_half_i (
        .cnt_clk(cnt_clk), .scan_clk(clk), .rst(rst), .latch_open(latch_open),
        .show_live(show_live), .seg(seg_w[2]), .dig_en(dig_w[2]), .carry_out(carry_w[2]));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int seg_exp(input int d);
        case (d)
            0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
            4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
            8: return 'h7F; 9: return 'h6F; default: return 0;
        endcase
    endfunction

    function automatic int seg_dec(input logic [6:0] s);
        for (int d = 0; d < 10; d++) if (int'(s) == seg_exp(d)) return d;
        return 15;
    endfunction

    function automatic int mmax(input int u, input int k);
        if (u == 1 && k == 2) return 5;
        if (u == 2 && k == 3) return 1;
        return 9;
    endfunction

    function automatic int mval(input int u);
        return mdig[u][0] + 10 * mdig[u][1] + 100 * mdig[u][2] + 1000 * mdig[u][3];
    endfunction

    task automatic model_step();
        for (int u = 0; u < 3; u++) begin
            bit go = 1'b1;
            for (int k = 0; k < 4; k++) begin
                if (go) begin
                    if (mdig[u][k] == mmax(u, k)) mdig[u][k] = 0;
                    else begin mdig[u][k]++; go = 1'b0; end
                end
            end
            if (u == 2) begin
                if (go) mcar[u] = 1;
            end else if (mval(u) == 0) mcar[u] = 0;
            else if (mval(u) == 6000) mcar[u] = 1;
        end
        if (latch_open) mhold = mval(0);
    endtask

    task automatic pulse();
        cnt_clk = 1'b1;
        @(negedge clk);
        cnt_clk = 1'b0;
        model_step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cnt_clk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int u = 0; u < 3; u++) begin
            mcar[u] = 0;
            for (int k = 0; k < 4; k++) mdig[u][k] = 0;
        end
        mhold = 0;
        @(negedge clk);
    endtask

    task automatic read_disp(input int u, output int val);
        int p = 1;
        repeat (8) @(negedge clk);
        val = 0;
        for (int k = 0; k < 4; k++) begin
            int guard = 0;
            while (dig_w[u] != (4'b0001 << k) && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            val += p * ((guard < 200) ? seg_dec(seg_w[u]) : 15);
            p *= 10;
        end
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int prev;
        int bad;
        process::self().srandom(32'd20240611);

        // R1: reset state
        do_reset();
        for (int u = 0; u < 3; u++) begin
            read_disp(u, v);
            chk("R1 display after reset", v, 0);
            chk("R1 carry after reset", int'(carry_w[u]), 0);
        end

        // R9: segment patterns of digit 0 for every value
        for (int d = 0; d < 10; d++) begin
            repeat (8) @(negedge clk);
            while (dig_w[0] != 4'b0001) @(negedge clk);
            chk($sformatf("R9 pattern of %0d", d), int'(seg_w[0]), seg_exp(d));
            pulse();
        end

        // R2: rising edge alone does not count, falling edge does
        do_reset();
        cnt_clk = 1'b1;
        read_disp(0, v);
        chk("R2 no count on rising edge", v, 0);
        cnt_clk = 1'b0;
        model_step();
        read_disp(0, v);
        chk("R2 count on falling edge", v, 1);

        // R8: scan order and dwell
        prev = int'(dig_w[0]);
        @(negedge clk);
        while (!(dig_w[0] == 4'b0001 && prev == 8)) begin
            prev = int'(dig_w[0]);
            @(negedge clk);
        end
        bad = 0;
        for (int c = 1; c < 4 * 4 * PD; c++) begin
            @(negedge clk);
            if (dig_w[0] != (4'b0001 << ((c / PD) % 4))) bad++;
        end
        chk("R8 scan order and dwell mismatches", bad, 0);

        // R7: random holding and display choice, plain decade unit
        do_reset();
        for (int it = 0; it < 40; it++) begin
            int n;
            latch_open = 1'($urandom % 2);
            show_live  = 1'($urandom % 2);
            if (latch_open) mhold = mval(0);
            n = int'($urandom % 25);
            for (int j = 0; j < n; j++) pulse();
            read_disp(0, v);
            chk($sformatf("R7 shown value open=%0d live=%0d", latch_open, show_live),
                v, show_live ? mval(0) : mhold);
        end
        latch_open = 1'b1;
        show_live  = 1'b1;

        // R3 R4 R5 R6: long sweep through every modulus corner
        do_reset();
        for (int n = 1; n <= 10002; n++) begin
            pulse();
            chk("R6 carry plain", int'(carry_w[0]), mcar[0]);
            chk("R6 carry clock", int'(carry_w[1]), mcar[1]);
            chk("R5 overflow flag", int'(carry_w[2]), mcar[2]);
            if (n == 10 || n == 100 || n == 600 || n == 1000 || n == 1999 ||
                n == 2000 || n == 2001 || n == 6000 || n == 9600 || n == 10000) begin
                read_disp(0, v);
                chk($sformatf("R3 decade count after %0d", n), v, mval(0));
                read_disp(1, v);
                chk($sformatf("R4 clock count after %0d", n), v, mval(1));
                read_disp(2, v);
                chk($sformatf("R5 half count after %0d", n), v, mval(2));
            end
        end

        // R1: reset clears a set overflow flag
        do_reset();
        chk("R1 overflow cleared by reset", int'(carry_w[2]), 0);
        read_disp(2, v);
        chk("R1 half display cleared", v, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule